// File: doc/BRIEF.md
# Mode-gated scratchpad access controller

This block stands between a processor load/store port and a word-wide on-chip scratchpad RAM. For each request it reads two status bits: a privilege bit and an extension-enable bit. From these bits and the logical address it decides whether the access is served, refused with an address error, or left alone because it is aimed somewhere other than the scratchpad.

Served accesses take one of two paths. The first is a fixed window at logical `0xA5xx_xxxx`. The second is a physical address that an external translation unit has already produced, which hits the scratchpad when it lies in `0x05xx_xxxx`. Fixed-window reads finish in one cycle. Fixed-window writes and every translated access finish in two. The scratchpad is shadowed, so only the low `SPAD_ADDR_BITS` bits of the chosen address select a byte. The default build uses 12 bits (4 kbytes). A full-size 128-kbyte part sets the parameter to 17.

Regions used below: low half (bit 31 = 0), upper-third region P3 (`0xC000_0000`–`0xDFFF_FFFF`), and the fixed window (bits 31:24 = `0xA5`).

Top module: `spadGate`

## Requirements
- R1: After reset, `done` and `addrErr` are low, and the controller is idle so that it accepts a request in the first cycle after reset.
- R2: With `statusMd`=1, whatever the value of `statusDsp`, a window address is served on the fixed path. The translation inputs have no effect on it, even when they flag a cacheable scratchpad hit.
- R3: On the fixed path, a read raises `done` for one cycle in the cycle after the request cycle, with `rdData` holding the addressed word. A write raises `done` in the second cycle after the request. A write changes only byte lanes i whose `reqBe[i]` is 1, where lane i is bits 8i+7..8i.
- R4: Only address bits `SPAD_ADDR_BITS-1`..2 select the word. Addresses that differ only above these bits, on either path, reach the same word.
- R5: With `statusMd`=0 and `statusDsp`=0, any address with bit 31 set, including the window, raises `addrErr` for one cycle in the cycle after the request. No `done` follows and the memory is not written.
- R6: With `statusMd`=0 and `statusDsp`=1, window addresses are served on the fixed path. Other addresses with bit 31 set raise `addrErr` as in R5.
- R7: A translated request is served when all of the following hold: its logical address is in the low half (any mode) or in P3 (privileged only), `xlatValid`=1, `xlatPaddr[31:24]`=`0x05`, and `xlatCacheable`=0. It uses the low bits of `xlatPaddr`, and `done` comes in the second cycle after the request for both reads and writes.
- R8: A translated request that would hit the scratchpad but has `xlatCacheable`=1 raises `addrErr` as in R5 and does not touch the memory.
- R9: A legal request that is not aimed at the scratchpad gives no `done`, no `addrErr` and no memory change. This covers a translated region with `xlatValid`=0 or with a physical address outside `0x05xx_xxxx`, and a privileged address with bit 31 set that is neither the window nor P3.
- R10: A request presented in the cycle after a two-cycle access was accepted is ignored.
- R11: `done` and `addrErr` are never high together, and each accepted request produces at most one single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Logical address |
| reqBe | input | 4 | Byte-lane enables for writes |
| reqWdata | input | 32 | Write data |
| statusMd | input | 1 | Privilege bit (1 = privileged) |
| statusDsp | input | 1 | Extension-enable bit |
| xlatValid | input | 1 | Translated address is valid |
| xlatCacheable | input | 1 | Cacheable attribute of the translation |
| xlatPaddr | input | 32 | Translated physical address |
| rdData | output | 32 | Read data, valid while `done` follows a read |
| done | output | 1 | One-cycle completion pulse |
| addrErr | output | 1 | One-cycle address-error pulse |

## Verification
A controller stuck in its wait state shows up at the ports one cycle later: the next request gets no `done` and no `addrErr`. A wrong route decode shows up in the first cycle after the request as a pulse on the wrong output, or as a missing pulse. A wrong held index or byte-enable register does not show up until a later read of the affected word returns data that differs from the model. For that reason, each location read in the random phase has first been written on a known path.

// File: rtl/spadGatePkg.sv
package spadGatePkg;

  typedef enum logic [1:0] {
    ROUTE_NONE,
    ROUTE_FIXED,
    ROUTE_XLAT,
    ROUTE_FAULT
  } routeE;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } ctrlStateE;

  typedef struct packed {
    logic capture;   // latch index, lanes and data for a two-cycle access
    logic srcXlat;   // index comes from the translated address
    logic readLive;  // read now from the request index
    logic readHeld;  // read from the latched index
    logic writeHeld; // write latched data to the latched index
  } memStrobeT;

endpackage

// File: rtl/spadGateRoute.sv
module spadGateRoute
  import spadGatePkg::*;
#(
  parameter logic [7:0] WIN_TAG  = 8'hA5,
  parameter logic [7:0] PHYS_TAG = 8'h05
) (
  input  logic        statusMd,
  input  logic        statusDsp,
  input  logic [31:0] reqAddr,
  input  logic        xlatValid,
  input  logic        xlatCacheable,
  input  logic [31:0] xlatPaddr,
  output routeE       route
);

  localparam logic [2:0] P3_TAG = 3'b110;

  logic  inWin;
  logic  inLow;
  logic  inP3;
  logic  physHit;
  routeE xlatRoute;

  always_comb begin
    inWin   = (reqAddr[31:24] == WIN_TAG);
    inLow   = !reqAddr[31];
    inP3    = (reqAddr[31:29] == P3_TAG);
    physHit = xlatValid && (xlatPaddr[31:24] == PHYS_TAG);

    if (!physHit)          xlatRoute = ROUTE_NONE;
    else if (xlatCacheable) xlatRoute = ROUTE_FAULT;
    else                   xlatRoute = ROUTE_XLAT;

    route = ROUTE_NONE;
    if (statusMd) begin
      if (inWin)              route = ROUTE_FIXED;
      else if (inLow || inP3) route = xlatRoute;
    end else if (inLow) begin
      route = xlatRoute;
    end else if (statusDsp && inWin) begin
      route = ROUTE_FIXED;
    end else begin
      route = ROUTE_FAULT;
    end
  end

endmodule

// File: rtl/spadGateCtrl.sv
module spadGateCtrl
  import spadGatePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  routeE     route,
  output memStrobeT strobes,
  output logic      done,
  output logic      addrErr
);

  ctrlStateE state, stateNext;
  logic      heldWrite;
  logic      accept;
  logic      doneNext;
  logic      errNext;

  always_comb begin
    accept    = reqValid && (state == ST_IDLE);
    strobes   = '0;
    stateNext = state;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    if (state == ST_WAIT) begin
      strobes.writeHeld = heldWrite;
      strobes.readHeld  = !heldWrite;
      doneNext          = 1'b1;
      stateNext         = ST_IDLE;
    end else if (accept) begin
      unique case (route)
        ROUTE_FIXED: begin
          if (reqWrite) begin
            strobes.capture = 1'b1;
            stateNext       = ST_WAIT;
          end else begin
            strobes.readLive = 1'b1;
            doneNext         = 1'b1;
          end
        end
        ROUTE_XLAT: begin
          strobes.capture = 1'b1;
          strobes.srcXlat = 1'b1;
          stateNext       = ST_WAIT;
        end
        ROUTE_FAULT: errNext = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      heldWrite <= 1'b0;
      done      <= 1'b0;
      addrErr   <= 1'b0;
    end else begin
      state   <= stateNext;
      done    <= doneNext;
      addrErr <= errNext;
      if (strobes.capture) heldWrite <= reqWrite;
    end
  end

  // R3
  fixed_rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && route == ROUTE_FIXED && !reqWrite) |=> done);

  // R7
  two_cycle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (route == ROUTE_XLAT || (route == ROUTE_FIXED && reqWrite)))
      |=> !done ##1 done);

  // R5
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && route == ROUTE_FAULT) |=> (addrErr && !done));

  // R9
  ignored_no_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && route == ROUTE_NONE) |=> (!done && !addrErr));

  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && addrErr));

endmodule

// File: rtl/spadGateDatapath.sv
module spadGateDatapath
  import spadGatePkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int SPAD_ADDR_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  memStrobeT            strobes,
  input  logic [SPAD_ADDR_BITS-1:$clog2(DATA_W/8)] reqIdx,
  input  logic [SPAD_ADDR_BITS-1:$clog2(DATA_W/8)] xlatIdx,
  input  logic [DATA_W/8-1:0]  reqBe,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic [DATA_W-1:0]    rdData
);

  localparam int BE_W      = DATA_W / 8;
  localparam int LANE_BITS = $clog2(BE_W);
  localparam int WORD_BITS = SPAD_ADDR_BITS - LANE_BITS;
  localparam int DEPTH     = 1 << WORD_BITS;

  logic [WORD_BITS-1:0] liveIdx;
  logic [WORD_BITS-1:0] heldIdx;
  logic [BE_W-1:0]      heldBe;
  logic [DATA_W-1:0]    heldData;

  assign liveIdx = strobes.srcXlat ? xlatIdx : reqIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldIdx  <= '0;
      heldBe   <= '0;
      heldData <= '0;
    end else if (strobes.capture) begin
      heldIdx  <= liveIdx;
      heldBe   <= reqBe;
      heldData <= reqWdata;
    end
  end

  for (genvar g = 0; g < BE_W; g++) begin : gLane
    logic [7:0] laneMem [DEPTH];
    logic [7:0] laneQ;

    always_ff @(posedge clk) begin
      if (strobes.writeHeld && heldBe[g]) laneMem[heldIdx] <= heldData[g*8 +: 8];
      if (strobes.readLive)               laneQ <= laneMem[liveIdx];
      else if (strobes.readHeld)          laneQ <= laneMem[heldIdx];
    end

    assign rdData[g*8 +: 8] = laneQ;
  end

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.readLive, strobes.readHeld, strobes.writeHeld}));

  // R10
  held_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeHeld || strobes.readHeld) |-> $past(strobes.capture));

endmodule

// File: rtl/spadGate.sv
module spadGate
  import spadGatePkg::*;
#(
  parameter int         SPAD_ADDR_BITS = 12,
  parameter logic [7:0] WIN_TAG        = 8'hA5,
  parameter logic [7:0] PHYS_TAG       = 8'h05
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [3:0]  reqBe,
  input  logic [31:0] reqWdata,
  input  logic        statusMd,
  input  logic        statusDsp,
  input  logic        xlatValid,
  input  logic        xlatCacheable,
  input  logic [31:0] xlatPaddr,
  output logic [31:0] rdData,
  output logic        done,
  output logic        addrErr
);

  localparam int DATA_W    = 32;
  localparam int LANE_BITS = $clog2(DATA_W / 8);

  routeE     route;
  memStrobeT strobes;

  spadGateRoute #(.WIN_TAG(WIN_TAG), .PHYS_TAG(PHYS_TAG)) route_i (
    .statusMd     (statusMd),
    .statusDsp    (statusDsp),
    .reqAddr      (reqAddr),
    .xlatValid    (xlatValid),
    .xlatCacheable(xlatCacheable),
    .xlatPaddr    (xlatPaddr),
    .route        (route)
  );

  spadGateCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .route   (route),
    .strobes (strobes),
    .done    (done),
    .addrErr (addrErr)
  );

  spadGateDatapath #(.DATA_W(DATA_W), .SPAD_ADDR_BITS(SPAD_ADDR_BITS)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqIdx  (reqAddr[SPAD_ADDR_BITS-1:LANE_BITS]),
    .xlatIdx (xlatPaddr[SPAD_ADDR_BITS-1:LANE_BITS]),
    .reqBe   (reqBe),
    .reqWdata(reqWdata),
    .rdData  (rdData)
  );

endmodule

// File: tb/spadGate_tb.sv
module spadGate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SPAD_BITS  = 12;
  localparam int WORDS      = 1 << (SPAD_BITS - 2);
  localparam int N_RANDOM   = 3000;
  localparam int K_NONE = 0, K_FIXED = 1, K_XLAT = 2, K_FAULT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0, xlatPaddr = '0;
  logic [3:0]  reqBe = '0;
  logic        statusMd = 1'b0, statusDsp = 1'b0, xlatValid = 1'b0, xlatCacheable = 1'b0;
  logic [31:0] rdData;
  logic        done, addrErr;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] model [WORDS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spadGate #(.SPAD_ADDR_BITS(SPAD_BITS)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .statusMd(statusMd), .statusDsp(statusDsp), .xlatValid(xlatValid),
    .xlatCacheable(xlatCacheable), .xlatPaddr(xlatPaddr),
    .rdData(rdData), .done(done), .addrErr(addrErr)
  );

  function automatic int expectKind(bit md, bit dsp, logic [31:0] a, bit xv, bit xc,
                                    logic [31:0] pa);
    bit win   = (a[31:24] == 8'hA5);
    bit low   = (a[31] == 1'b0);
    bit p3    = (a[31:28] == 4'hC) || (a[31:28] == 4'hD);
    int trans = !(xv && pa[31:24] == 8'h05) ? K_NONE : (xc ? K_FAULT : K_XLAT);
    if (md) return win ? K_FIXED : ((low || p3) ? trans : K_NONE);
    if (low) return trans;
    if (dsp && win) return K_FIXED;
    return K_FAULT;
  endfunction

  function automatic string tagOf(int kind, bit md, bit dsp, bit xc);
    case (kind)
      K_FIXED: return md ? "R2" : "R6";
      K_XLAT:  return "R7";
      K_FAULT: return xc && (md || !dsp) ? "R8" : (dsp ? "R6" : "R5");
      default: return "R9";
    endcase
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  task automatic check(bit ok, string tag, string msg);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic drive(bit md, bit dsp, bit wr, logic [31:0] a, logic [3:0] be,
                       logic [31:0] wd, bit xv, bit xc, logic [31:0] pa);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqBe = be; reqWdata = wd;
    statusMd = md; statusDsp = dsp; xlatValid = xv; xlatCacheable = xc; xlatPaddr = pa;
  endtask

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] wd, logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = wd[i*8 +: 8];
    return r;
  endfunction

  // Issues one request at a negedge and checks both following cycles.
  task automatic issue(bit md, bit dsp, bit wr, logic [31:0] a, logic [3:0] be,
                       logic [31:0] wd, bit xv, bit xc, logic [31:0] pa, string tag);
    int kind = expectKind(md, dsp, a, xv, xc, pa);
    int idx  = (kind == K_XLAT) ? int'(pa[SPAD_BITS-1:2]) : int'(a[SPAD_BITS-1:2]);
    logic [31:0] expRd = model[idx];
    string t = (tag == "") ? tagOf(kind, md, dsp, xc) : tag;
    logic d1, e1, d2, e2;
    logic [31:0] r1, r2;
    bit eD1 = (kind == K_FIXED) && !wr;
    bit eD2 = ((kind == K_FIXED) && wr) || (kind == K_XLAT);
    bit eE1 = (kind == K_FAULT);
    drive(md, dsp, wr, a, be, wd, xv, xc, pa);
    @(negedge clk);
    d1 = done; e1 = addrErr; r1 = rdData;
    reqValid = 1'b0;
    @(negedge clk);
    d2 = done; e2 = addrErr; r2 = rdData;
    check(d1 === eD1 && e1 === eE1 && d2 === eD2 && e2 === 1'b0, t,
          $sformatf("addr=%h pa=%h done/err=%b%b,%b%b expected %b%b,%b%b",
                    a, pa, d1, e1, d2, e2, eD1, eE1, eD2, 1'b0));
    check(!(d1 && e1) && !(d2 && e2), "R11",
          $sformatf("done/err overlap %b%b,%b%b expected no overlap", d1, e1, d2, e2));
    if (!wr && (kind == K_FIXED || kind == K_XLAT)) begin
      logic [31:0] got = (kind == K_FIXED) ? r1 : r2;
      check(got === expRd, t, $sformatf("rdData=%h expected %h (word %0d)", got, expRd, idx));
    end
    if (wr && (kind == K_FIXED || kind == K_XLAT)) model[idx] = merge(model[idx], wd, be);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5CA7_7E11));
    repeat (3) @(negedge clk);
    // R1: outputs quiet during and right after reset
    check(done === 1'b0 && addrErr === 1'b0, "R1",
          $sformatf("in reset done=%b err=%b expected 0 0", done, addrErr));
    rstN = 1'b1;
    @(negedge clk);
    check(done === 1'b0 && addrErr === 1'b0, "R1",
          $sformatf("after reset done=%b err=%b expected 0 0", done, addrErr));

    // Prefill every word through the fixed window; R1 idle accept on first one
    for (int i = 0; i < WORDS; i++)
      issue(1'b1, 1'b0, 1'b1, 32'hA500_0000 + 32'(i * 4), 4'hF,
            32'h3C00_0000 ^ 32'(i * 32'h0001_0103), 1'b0, 1'b0, '0, (i == 0) ? "R1" : "R3");

    // R2: window wins over a cacheable translated hit
    issue(1'b1, 1'b1, 1'b0, 32'hA500_0040, 4'hF, '0, 1'b1, 1'b1, 32'h0500_0040, "R2");
    // R3: partial byte enables
    issue(1'b1, 1'b0, 1'b1, 32'hA500_0100, 4'b0101, 32'hDEAD_BEEF, 1'b0, 1'b0, '0, "R3");
    issue(1'b1, 1'b0, 1'b0, 32'hA500_0100, 4'h0, '0, 1'b0, 1'b0, '0, "R3");
    // R4: aliased window and translated addresses reach one word
    issue(1'b1, 1'b1, 1'b1, 32'hA57F_0010, 4'hF, 32'h1234_5678, 1'b0, 1'b0, '0, "R4");
    issue(1'b1, 1'b0, 1'b0, 32'hA500_0010, 4'h0, '0, 1'b0, 1'b0, '0, "R4");
    issue(1'b0, 1'b0, 1'b0, 32'h0000_2000, 4'h0, '0, 1'b1, 1'b0, 32'h05AB_C010, "R4");
    // R5: user without extension cannot use the window; memory unchanged
    issue(1'b0, 1'b0, 1'b1, 32'hA500_0200, 4'hF, 32'hFFFF_0000, 1'b0, 1'b0, '0, "R5");
    issue(1'b1, 1'b0, 1'b0, 32'hA500_0200, 4'h0, '0, 1'b0, 1'b0, '0, "R5");
    // R6: user with extension
    issue(1'b0, 1'b1, 1'b0, 32'hA5FF_F204, 4'h0, '0, 1'b0, 1'b0, '0, "R6");
    issue(1'b0, 1'b1, 1'b1, 32'h8000_0000, 4'hF, 32'h0, 1'b0, 1'b0, '0, "R6");
    // R7: translated write from P3 in privileged mode, then read back
    issue(1'b1, 1'b0, 1'b1, 32'hC123_4000, 4'hF, 32'h0BAD_F00D, 1'b1, 1'b0, 32'h0500_0300, "R7");
    issue(1'b0, 1'b1, 1'b0, 32'h0000_0300, 4'h0, '0, 1'b1, 1'b0, 32'h0500_0300, "R7");
    // R8: cacheable scratchpad hit refused, memory untouched
    issue(1'b0, 1'b0, 1'b1, 32'h0000_0300, 4'hF, 32'h0, 1'b1, 1'b1, 32'h0500_0300, "R8");
    issue(1'b1, 1'b0, 1'b0, 32'hA500_0300, 4'h0, '0, 1'b0, 1'b0, '0, "R8");
    // R9: not aimed at the scratchpad
    issue(1'b1, 1'b0, 1'b1, 32'hA000_0300, 4'hF, 32'h0, 1'b0, 1'b0, '0, "R9");
    issue(1'b1, 1'b1, 1'b1, 32'h0000_0300, 4'hF, 32'h0, 1'b0, 1'b0, 32'h0500_0300, "R9");
    issue(1'b0, 1'b0, 1'b1, 32'h0000_0300, 4'hF, 32'h0, 1'b1, 1'b0, 32'h0600_0300, "R9");
    issue(1'b1, 1'b0, 1'b0, 32'hA500_0300, 4'h0, '0, 1'b0, 1'b0, '0, "R9");

    // R10: request in the wait cycle of a two-cycle write is ignored
    begin
      logic d1, d2, d3;
      drive(1'b1, 1'b0, 1'b1, 32'hA500_0400, 4'hF, 32'hAAAA_0001, 1'b0, 1'b0, '0);
      @(negedge clk);
      d1 = done;
      drive(1'b1, 1'b0, 1'b1, 32'hA500_0404, 4'hF, 32'hBBBB_0002, 1'b0, 1'b0, '0);
      @(negedge clk);
      d2 = done;
      reqValid = 1'b0;
      @(negedge clk);
      d3 = done;
      model[256] = 32'hAAAA_0001;
      check(d1 === 1'b0 && d2 === 1'b1 && d3 === 1'b0, "R10",
            $sformatf("done seq %b%b%b expected 010", d1, d2, d3));
      issue(1'b1, 1'b0, 1'b0, 32'hA500_0404, 4'h0, '0, 1'b0, 1'b0, '0, "R10");
      issue(1'b1, 1'b0, 1'b0, 32'hA500_0400, 4'h0, '0, 1'b0, 1'b0, '0, "R10");
    end

    // Constrained random mix
    for (int n = 0; n < N_RANDOM; n++) begin
      logic [31:0] a, pa, r;
      r = $urandom;
      case ($urandom % 6)
        0, 1:    a = {8'hA5, r[23:0]};
        2:       a = {1'b0, r[30:0]};
        3:       a = {3'b110, r[28:0]};
        default: a = {1'b1, r[30:0]};
      endcase
      pa = ($urandom % 4 != 0) ? {8'h05, 24'($urandom)} : $urandom;
      issue(1'($urandom), 1'($urandom), 1'($urandom), a, 4'($urandom), $urandom,
            ($urandom % 8) != 0, ($urandom % 7) == 0, pa, "");
    end

    summary();
    $finish;
  end

endmodule